// File: doc/BRIEF.md
# Programmable Multi-Pulse Generator

This block emits a burst of pulses once it is triggered. A trigger is either a rising edge on the `start_i` input or a write of 1 to bit 0 of the control register. After the trigger the block waits a set delay. It then produces N+1 pulses. Each pulse has a set width, and a set gap separates one pulse from the next. The output can be active-high or active-low. When the last pulse ends, the block goes straight back to idle and raises `ready_o`.

Software sets the block up over a byte-wide register bus. Each timing value is wider than one byte. It is loaded by writing several bytes in a row to the same offset, most significant byte first. Every write moves the register up by one byte and places the new byte at the bottom. The 24-bit timing fields and the 16-bit count are both loaded this way. All counts are in system clock cycles, and a programmed value V means V+1 cycles (or V+1 pulses for the count).

Top module: `pulse_burst_gen`

## Requirements
- R1: After reset, every register is zero and the output is active-high, so `pulse_o` is 0, `ready_o` is 1 and `rd_data_o` is 0. With these values, one trigger gives a single pulse of one cycle, and its active cycle starts one clock after the trigger edge.
- R2: The offsets are 0 status (read), 1 control, 2 config, 3 delay, 4 interval, 5 width and 6 count. A write to offset 7 changes nothing.
- R3: A read strobe at offset 0 puts `ready_o` into bit 0 of `rd_data_o` one cycle later, with all other bits 0. A read at any other offset returns 0. Between read strobes, `rd_data_o` holds its value.
- R4: When the block is ready, a write to offset 1 with bit 0 set starts a burst, and `ready_o` falls after that edge. A write to offset 1 with bit 0 clear does nothing.
- R5: When the block is ready, a rising edge of `start_i` starts a burst. Holding `start_i` high does not start another burst.
- R6: With delay value D, the first active cycle of `pulse_o` comes D+1 cycles after the trigger edge.
- R7: With width value W, each pulse stays active for W+1 cycles.
- R8: With interval value I, there are I+1 inactive cycles between the end of one pulse and the start of the next.
- R9: With count value N, the block emits N+1 pulses. `ready_o` returns to 1 in the cycle that follows the last active cycle.
- R10: Config bit 0 sets the polarity. When it is 1, the pulses are active-low and the idle level is high.
- R11: Offsets 3, 4 and 5 take three byte writes, MSB first, and offset 6 takes two. Each write shifts the register left by 8 bits and fills the low byte, so extra writes push the oldest bytes out.
- R12: A trigger that arrives while a burst is running is ignored. The running burst is not changed, and no new burst starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | External trigger, rising-edge sensitive, synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register offset |
| wr_data_i | input | 8 | Write data byte |
| rd_data_o | output | 8 | Read data, registered |
| pulse_o | output | 1 | Pulse output, polarity set by config |
| ready_o | output | 1 | High while idle and able to accept a trigger |

## Verification
The assertions assume three things about the inputs:
- `start_i` is already synchronous to `clk`.
- A config write never lands in the same cycle as a trigger.
- Polarity is not changed in the middle of a burst.

The bench respects all three. It changes config only while `ready_o` is high, and it never writes a register in the same cycle as a start edge. Random bursts keep delay, width and interval below 8 and the count below 5, so every burst stays short. One directed burst uses a delay of several hundred cycles to exercise the upper bytes.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_WIDTH = 2'd2,
      ST_GAP   = 2'd3
   } pbg_state_e;

   localparam int unsigned OFS_STATUS = 0;
   localparam int unsigned OFS_CTRL   = 1;
   localparam int unsigned OFS_CFG    = 2;
   localparam int unsigned OFS_DELAY  = 3;
   localparam int unsigned OFS_GAP    = 4;
   localparam int unsigned OFS_WIDTH  = 5;
   localparam int unsigned OFS_COUNT  = 6;

   // timing slots: 0 = delay, 1 = width, 2 = interval
   localparam int unsigned NUM_TIM = 3;
endpackage

// File: rtl/pbg_shreg.sv
// Byte-serial loadable register: each load shifts in one byte at the bottom.
module pbg_shreg #(
   parameter int unsigned W  = 24,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [DW-1:0] din,
   output logic [W-1:0]  q
);
   generate
      if (W > DW) begin : g_shift
         always_ff @(posedge clk) begin
            if (!rst_n)  q <= '0;
            else if (ld) q <= {q[W-DW-1:0], din};
         end
      end else begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n)  q <= '0;
            else if (ld) q <= din[W-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/pbg_regs.sv
module pbg_regs
   import pbg_pkg::*;
#(
   parameter int unsigned AW = 3,
   parameter int unsigned DW = 8,
   parameter int unsigned TW = 24,
   parameter int unsigned CW = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [AW-1:0]              addr,
   input  logic [DW-1:0]              wr_data,
   output logic                       fire,
   output logic                       pol,
   output logic [NUM_TIM-1:0][TW-1:0] tim,
   output logic [CW-1:0]              cnt
);
   localparam int unsigned TIM_OFS [NUM_TIM] = '{OFS_DELAY, OFS_WIDTH, OFS_GAP};

   assign fire = wr_en && (addr == AW'(OFS_CTRL)) && wr_data[0];

   always_ff @(posedge clk) begin
      if (!rst_n)
         pol <= 1'b0;
      else if (wr_en && addr == AW'(OFS_CFG))
         pol <= wr_data[0];
   end

   generate
      for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
         pbg_shreg #(.W(TW), .DW(DW)) u_tim (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (wr_en && addr == AW'(TIM_OFS[g])),
            .din   (wr_data),
            .q     (tim[g])
         );
      end
   endgenerate

   pbg_shreg #(.W(CW), .DW(DW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (wr_en && addr == AW'(OFS_COUNT)),
      .din   (wr_data),
      .q     (cnt)
   );
endmodule

// File: rtl/pbg_seq.sv
module pbg_seq
   import pbg_pkg::*;
#(
   parameter int unsigned TW = 24,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig,
   input  logic [TW-1:0] dly,
   input  logic [TW-1:0] wid,
   input  logic [TW-1:0] gap,
   input  logic [CW-1:0] cnt,
   output logic          active,
   output logic          idle
);
   pbg_state_e    state;
   logic [TW-1:0] tcnt;
   logic [CW-1:0] rem;
   logic          tzero;

   assign tzero  = (tcnt == '0);
   assign active = (state == ST_WIDTH);
   assign idle   = (state == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         tcnt  <= '0;
         rem   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (trig) begin
               state <= ST_DELAY;
               tcnt  <= dly;
               rem   <= cnt;
            end
            ST_DELAY: if (tzero) begin
               state <= ST_WIDTH;
               tcnt  <= wid;
            end else tcnt <= tcnt - TW'(1);
            ST_WIDTH: if (tzero) begin
               if (rem == '0) state <= ST_IDLE;
               else begin
                  state <= ST_GAP;
                  tcnt  <= gap;
                  rem   <= rem - CW'(1);
               end
            end else tcnt <= tcnt - TW'(1);
            ST_GAP: if (tzero) begin
               state <= ST_WIDTH;
               tcnt  <= wid;
            end else tcnt <= tcnt - TW'(1);
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen
   import pbg_pkg::*;
#(
   parameter int unsigned AW = 3,
   parameter int unsigned DW = 8,
   parameter int unsigned TW = 24,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          wr_en_i,
   input  logic          rd_en_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wr_data_i,
   output logic [DW-1:0] rd_data_o,
   output logic          pulse_o,
   output logic          ready_o
);
   generate
      if (AW < 3) begin : g_bad_aw
         $error("pulse_burst_gen: AW must cover offsets 0..6");
      end
      if (TW % DW != 0 || CW % DW != 0) begin : g_bad_w
         $error("pulse_burst_gen: TW and CW must be whole bytes");
      end
   endgenerate

   logic                       fire, cfg_pol, start_q, start_rise;
   logic [NUM_TIM-1:0][TW-1:0] tim;
   logic [CW-1:0]              cnt;
   logic                       active, idle;

   pbg_regs #(.AW(AW), .DW(DW), .TW(TW), .CW(CW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_i),
      .addr    (addr_i),
      .wr_data (wr_data_i),
      .fire    (fire),
      .pol     (cfg_pol),
      .tim     (tim),
      .cnt     (cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) start_q <= 1'b0;
      else        start_q <= start_i;
   end
   assign start_rise = start_i && !start_q;

   pbg_seq #(.TW(TW), .CW(CW)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (fire || start_rise),
      .dly    (tim[0]),
      .wid    (tim[1]),
      .gap    (tim[2]),
      .cnt    (cnt),
      .active (active),
      .idle   (idle)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_data_o <= '0;
      else if (rd_en_i)
         rd_data_o <= (addr_i == AW'(OFS_STATUS)) ? DW'(idle) : '0;
   end

   assign pulse_o = active ^ cfg_pol;
   assign ready_o = idle;
endmodule

// File: rtl/pbg_checker.sv
module pbg_checker #(
   parameter int unsigned AW = 3,
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          wr_en_i,
   input logic          rd_en_i,
   input logic [AW-1:0] addr_i,
   input logic [DW-1:0] wr_data_i,
   input logic [DW-1:0] rd_data_o,
   input logic          pulse_o,
   input logic          ready_o,
   input logic          cfg_pol
);
   logic fire_wr, cfg_wr;
   assign fire_wr = wr_en_i && addr_i == AW'(1) && wr_data_i[0];
   assign cfg_wr  = wr_en_i && addr_i == AW'(2);

   // R10: while idle, the output rests at the level chosen by polarity
   a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> pulse_o == cfg_pol);

   // R4: a fire write on an idle block starts a burst
   a_r4_fire_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && fire_wr) |=> !ready_o);

   // R5: a rising start edge on an idle block starts a burst
   a_r5_start_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && $rose(start_i)) |=> !ready_o);

   // R6: the delay lasts at least one cycle, so no pulse in the cycle after a trigger
   a_r6_no_instant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && (fire_wr || $rose(start_i)) && !cfg_wr) |=> pulse_o == cfg_pol);

   // R3: a status read returns ready in bit 0, other bits zero
   a_r3_status_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && addr_i == AW'(0)) |=>
         (rd_data_o[0] == $past(ready_o)) && (rd_data_o[DW-1:1] == '0));

   // R3: read data holds between strobes
   a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rd_data_o));
endmodule

bind pulse_burst_gen pbg_checker #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .wr_en_i   (wr_en_i),
   .rd_en_i   (rd_en_i),
   .addr_i    (addr_i),
   .wr_data_i (wr_data_i),
   .rd_data_o (rd_data_o),
   .pulse_o   (pulse_o),
   .ready_o   (ready_o),
   .cfg_pol   (cfg_pol)
);

// File: tb/pulse_burst_gen_bench.sv
module pulse_burst_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic       rd_en_i = 1'b0;
   logic [2:0] addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic [7:0] rd_data_o;
   logic       pulse_o, ready_o;

   int  checks = 0;
   int  fails  = 0;
   bit  pol    = 1'b0;

   always #4 clk = ~clk;

   pulse_burst_gen u_pulse_burst_gen (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .wr_en_i (wr_en_i),
      .rd_en_i (rd_en_i), .addr_i (addr_i), .wr_data_i (wr_data_i),
      .rd_data_o (rd_data_o), .pulse_o (pulse_o), .ready_o (ready_o)
   );

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_active(int j, int d, int w, int i, int n);
      int r, p;
      if (j < d + 1) return 1'b0;
      r = j - d - 1;
      p = r / (w + i + 2);
      if (p > n) return 1'b0;
      return (r % (w + i + 2)) <= w;
   endfunction

   function automatic int burst_len(int d, int w, int i, int n);
      return d + 1 + n * (w + i + 2) + w + 1;
   endfunction

   task automatic wr(int a, int v);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = 3'(a); wr_data_i = 8'(v);
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic load24(int a, int v);
      wr(a, (v >> 16) & 255); wr(a, (v >> 8) & 255); wr(a, v & 255);
   endtask

   task automatic load16(int a, int v);
      wr(a, (v >> 8) & 255); wr(a, v & 255);
   endtask

   task automatic setup(int d, int w, int i, int n);
      load24(3, d); load24(5, w); load24(4, i); load16(6, n);
   endtask

   task automatic check_idle(int cycles, string req);
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         check(ready_o === 1'b1, req, ready_o, 1);
         check(pulse_o === pol, req, pulse_o, pol);
      end
   endtask

   task automatic run_burst(int d, int w, int i, int n, bit use_start, bit retrig, string req);
      int total = burst_len(d, w, i, n);
      @(negedge clk);
      if (use_start) start_i = 1'b1;
      else begin wr_en_i = 1'b1; addr_i = 3'd1; wr_data_i = 8'h01; end
      @(posedge clk);
      for (int j = 0; j < total + 3; j++) begin
         bit ea, er;
         @(negedge clk);
         wr_en_i = 1'b0; rd_en_i = 1'b0;
         ea = exp_active(j, d, w, i, n);
         er = (j >= total);
         check((pulse_o === (ea ^ pol)) && (ready_o === er), req,
               {pulse_o, ready_o}, {ea ^ pol, er});
         if (j == 0) begin rd_en_i = 1'b1; addr_i = 3'd0; end
         if (j == 1) begin
            check(rd_data_o === 8'h00, "R3 busy status", rd_data_o, 0);
            if (retrig) begin wr_en_i = 1'b1; addr_i = 3'd1; wr_data_i = 8'h01; end
         end
      end
      start_i = 1'b0;
   endtask

   task automatic read_status(int a, int exp, string req);
      @(negedge clk);
      rd_en_i = 1'b1; addr_i = 3'(a);
      @(negedge clk);
      rd_en_i = 1'b0;
      check(rd_data_o === 8'(exp), req, rd_data_o, exp);
      @(negedge clk);
      check(rd_data_o === 8'(exp), "R3 hold", rd_data_o, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ready_o === 1'b1, "R1 ready", ready_o, 1);
      check(pulse_o === 1'b0, "R1 pulse", pulse_o, 0);
      check(rd_data_o === 8'h00, "R1 rd_data", rd_data_o, 0);
      read_status(0, 1, "R3 idle status");
      read_status(5, 0, "R3 other offset");
      // R1 default one-cycle pulse
      run_burst(0, 0, 0, 0, 1'b0, 1'b0, "R1 default burst");
      // R6 R7 R8 R9 directed
      setup(2, 1, 3, 2);
      run_burst(2, 1, 3, 2, 1'b0, 1'b0, "R6 R7 R8 R9 directed");
      // R4 fire with bit 0 clear
      wr(1, 8'h00); wr(1, 8'hFE);
      check_idle(3, "R4 bit0 clear");
      // R5 start edge, level held; R12 retrigger ignored
      run_burst(2, 1, 3, 2, 1'b1, 1'b1, "R5 R12 start and retrigger");
      // R10 polarity
      wr(2, 1); pol = 1'b1;
      check_idle(2, "R10 idle high");
      run_burst(2, 1, 3, 2, 1'b0, 1'b0, "R10 inverted burst");
      wr(2, 0); pol = 1'b0;
      // R11 extra bytes push out oldest
      wr(3, 8'hAA); wr(3, 0); wr(3, 0); wr(3, 3);
      wr(6, 8'h77); wr(6, 0); wr(6, 1);
      run_burst(3, 1, 3, 1, 1'b0, 1'b0, "R11 byte shift");
      // R2 unmapped offset 7
      wr(7, 8'hFF);
      run_burst(3, 1, 3, 1, 1'b0, 1'b0, "R2 offset 7 ignored");
      // R6 large delay uses upper byte
      setup(300, 2, 0, 1);
      run_burst(300, 2, 0, 1, 1'b0, 1'b0, "R6 long delay");
      // random bursts
      for (int t = 0; t < 30; t++) begin
         int d = $urandom_range(0, 7);
         int w = $urandom_range(0, 7);
         int i = $urandom_range(0, 7);
         int n = $urandom_range(0, 4);
         bit s = 1'($urandom_range(0, 1));
         bit r = 1'($urandom_range(0, 1));
         setup(d, w, i, n);
         run_burst(d, w, i, n, s, r, "R6 R7 R8 R9 R12 random");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule